// File: doc/BRIEF.md
# Variable-Page-Size Fully Associative Translation Buffer

This block caches virtual-to-physical page translations in a fully associative array of 64 entries. Each entry sets its own page size, from 1 KB up to 64 MB. The page size decides two things. It sets how many upper virtual address bits the lookup compares. It also sets how many low address bits pass through untranslated as the page offset. A 32-bit virtual address goes in and a 29-bit physical address comes out.

A lookup presents a virtual address, the current address space identifier and two mode controls. The first control selects single or multiple virtual memory mode. The second tells user accesses from privileged ones. Every entry is compared in parallel. The outcome is registered one cycle after the lookup strobe, together with the matching entry's attribute bits. A write port loads or clears one entry by index, and a separate input clears every entry at once.

Replacement, page-table walking, exceptions and permission checks belong to the surrounding logic.

Top module: `vpsz_tlb`

## Requirements
- R1: A lookup strobe on `lk_valid` at a clock edge makes `rs_valid` 1 after that edge. After an edge without a strobe, `rs_valid` is 0 and every other result output keeps its previous value.
- R2: A write with `wr_en` replaces entry `wr_index` at the clock edge. A lookup at that same edge still sees the old contents, and the next lookup sees the new ones. Writing `wr_valid`=0 removes the entry, and an entry with valid 0 never matches.
- R3: Size codes 0 to 7 select page offsets of 10, 12, 13, 16, 18, 20, 22 and 26 bits. An entry matches only when the virtual address bits from the offset width up to bit 31 equal the stored page-number bits at the same positions. Stored page-number bits below the offset width are ignored.
- R4: An entry holding a size code from 8 to 15 never matches.
- R5: On a hit, `rs_paddr` takes the bits below the offset width from the virtual address and the bits above it from the entry's physical page number. Page-number bits that lie inside the offset are ignored.
- R6: An entry with its share bit at 1 matches whatever the value of `lk_asid`.
- R7: An entry with share 0 matches only if its identifier equals `lk_asid`. This applies when `lk_single_vm`=0, and also when `lk_single_vm`=1 with `lk_user`=1.
- R8: When `lk_single_vm`=1 and `lk_user`=0, the identifier is not compared for any entry.
- R9: When two or more entries match, `rs_multi` is 1 and `rs_hit` is 0, and the physical address and all attribute outputs are 0.
- R10: When no entry matches, `rs_hit` and `rs_multi` are 0, and the physical address and attributes are 0.
- R11: `inv_all` clears every entry's valid bit at the clock edge. If `wr_en` is also 1 at that edge, the write is dropped.
- R12: On a hit, `rs_prot`, `rs_cache`, `rs_dirty`, `rs_wt` and `rs_share` carry the matching entry's stored bits.
- R13: Reset empties every entry and sets all result outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup strobe |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Current address space identifier |
| lk_single_vm | input | 1 | 1 = single virtual memory mode |
| lk_user | input | 1 | 1 = user-mode access, 0 = privileged |
| wr_en | input | 1 | Entry write strobe |
| wr_index | input | 6 | Entry to write |
| wr_valid | input | 1 | Valid bit to store (0 removes the entry) |
| wr_vpn | input | 22 | Virtual page number, address bits 31 to 10 |
| wr_asid | input | 8 | Identifier to store |
| wr_ppn | input | 19 | Physical page number, address bits 28 to 10 |
| wr_size | input | 4 | Page size code |
| wr_share | input | 1 | Share bit to store |
| wr_cache | input | 1 | Cacheable bit to store |
| wr_dirty | input | 1 | Dirty bit to store |
| wr_wt | input | 1 | Write-through bit to store |
| wr_prot | input | 6 | Protection field to store |
| inv_all | input | 1 | Clear every entry |
| rs_valid | output | 1 | Result strobe, one cycle after `lk_valid` |
| rs_hit | output | 1 | Exactly one entry matched |
| rs_multi | output | 1 | More than one entry matched |
| rs_paddr | output | 29 | Translated physical address |
| rs_prot | output | 6 | Protection field of the hit entry |
| rs_cache | output | 1 | Cacheable bit of the hit entry |
| rs_dirty | output | 1 | Dirty bit of the hit entry |
| rs_wt | output | 1 | Write-through bit of the hit entry |
| rs_share | output | 1 | Share bit of the hit entry |

## Verification
The embedded assertions check the per-cycle rules on every cycle: the result strobe follows the lookup strobe, and results hold between strobes. They also check that a reserved size never matches and that a clear-all empties each entry. A write lands in its entry, a multiple match never reports a hit, and a hit keeps the low ten address bits. Some properties need chosen stimulus, and only the bench scenarios show them. These are the exact boundary where each page size stops matching, where page and offset bits are spliced in the physical address, and the full grid of identifier-checking modes. The same holds for ordering between a write and a lookup at the same edge, and for every one of the 64 slots answering at its own index.

// File: rtl/vpsz_tlb_pkg.sv
package vpsz_tlb_pkg;

    parameter int VA_W   = 32;
    parameter int PA_W   = 29;
    parameter int ASID_W = 8;
    parameter int PG_MIN = 10;
    parameter int PROT_W = 6;
    parameter int SZ_W   = 4;
    parameter int SH_W   = 5;
    parameter int VPN_W  = VA_W - PG_MIN;
    parameter int PPN_W  = PA_W - PG_MIN;

    typedef struct packed {
        logic [PROT_W-1:0] prot;
        logic              cache;
        logic              dirty;
        logic              wt;
        logic              share;
    } pg_attr_t;

    typedef struct packed {
        logic              valid;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
        logic [SZ_W-1:0]   size;
        pg_attr_t          attr;
    } pg_rec_t;

    // Offset width selected by a legal size code.
    function automatic logic [SH_W-1:0] size_to_shift(input logic [SZ_W-1:0] code);
        logic [SH_W-1:0] s;
        case (code[2:0])
            3'd0:    s = SH_W'(10);
            3'd1:    s = SH_W'(12);
            3'd2:    s = SH_W'(13);
            3'd3:    s = SH_W'(16);
            3'd4:    s = SH_W'(18);
            3'd5:    s = SH_W'(20);
            3'd6:    s = SH_W'(22);
            default: s = SH_W'(26);
        endcase
        return s;
    endfunction

    function automatic logic size_is_legal(input logic [SZ_W-1:0] code);
        return code < SZ_W'(8);
    endfunction

endpackage

// File: rtl/vpsz_tlb_slot.sv
module vpsz_tlb_slot
    import vpsz_tlb_pkg::*;
#(
    parameter int IDX_W  = 6,
    parameter int MY_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_index,
    input  pg_rec_t           wr_rec,
    input  logic              inv_all,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              asid_chk,
    output logic              match,
    output logic [PA_W-1:0]   xl_paddr,
    output pg_attr_t          xl_attr
);

    pg_rec_t ent_d, ent_q;

    logic            sel;
    logic [SH_W-1:0] shift;
    logic [VPN_W-1:0] cmp_mask;
    logic [PA_W-1:0]  off_mask;
    logic [PA_W-1:0]  ppn_full;
    logic             vpn_eq, asid_ok;

    assign sel = wr_en && (wr_index == IDX_W'(MY_IDX));

    always_comb begin
        ent_d = ent_q;
        if (inv_all) begin
            ent_d.valid = 1'b0;
        end else if (sel) begin
            ent_d = wr_rec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_q <= '0;
        end else begin
            ent_q <= ent_d;
        end
    end

    always_comb begin
        shift = size_to_shift(ent_q.size);
        for (int i = 0; i < VPN_W; i++) begin
            cmp_mask[i] = (i + PG_MIN) >= int'(shift);
        end
        for (int j = 0; j < PA_W; j++) begin
            off_mask[j] = j < int'(shift);
        end
        ppn_full = {ent_q.ppn, {PG_MIN{1'b0}}};
        vpn_eq   = ((lk_vaddr[VA_W-1:PG_MIN] ^ ent_q.vpn) & cmp_mask) == '0;
        asid_ok  = ent_q.attr.share || !asid_chk || (ent_q.asid == lk_asid);
        match    = ent_q.valid && size_is_legal(ent_q.size) && vpn_eq && asid_ok;
        xl_paddr = (lk_vaddr[PA_W-1:0] & off_mask) | (ppn_full & ~off_mask);
        xl_attr  = ent_q.attr;
    end

    a_r11_inv_clears: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> !ent_q.valid);

    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !inv_all) |=> (ent_q == $past(wr_rec)));

    a_r4_reserved_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !size_is_legal(ent_q.size) |-> !match);

endmodule

// File: rtl/vpsz_tlb_merge.sv
module vpsz_tlb_merge
    import vpsz_tlb_pkg::*;
#(
    parameter int N_ENTRIES = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_ENTRIES-1:0]          match,
    input  logic [N_ENTRIES-1:0][PA_W-1:0] slot_pa,
    input  pg_attr_t [N_ENTRIES-1:0]      slot_attr,
    output logic                          hit,
    output logic                          multi,
    output logic [PA_W-1:0]               paddr,
    output pg_attr_t                      attr
);

    localparam int CNT_W = $clog2(N_ENTRIES) + 1;

    logic [CNT_W-1:0] cnt;
    logic [PA_W-1:0]  pa_or;
    pg_attr_t         at_or;

    always_comb begin
        cnt   = '0;
        pa_or = '0;
        at_or = '0;
        for (int k = 0; k < N_ENTRIES; k++) begin
            cnt   = cnt + CNT_W'(match[k]);
            pa_or = pa_or | (slot_pa[k] & {PA_W{match[k]}});
            at_or = at_or | (slot_attr[k] & {$bits(pg_attr_t){match[k]}});
        end
        hit   = (cnt == CNT_W'(1));
        multi = (cnt > CNT_W'(1));
        paddr = hit ? pa_or : '0;
        attr  = hit ? at_or : '0;
    end

    a_r9_multi_not_hit: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(match) > 1) |-> (multi && !hit && paddr == '0));

    a_r10_miss_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (match == '0) |-> (!hit && !multi && attr == '0));

endmodule

// File: rtl/vpsz_tlb.sv
module vpsz_tlb
    import vpsz_tlb_pkg::*;
#(
    parameter int N_ENTRIES = 64,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_single_vm,
    input  logic              lk_user,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_index,
    input  logic              wr_valid,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [PPN_W-1:0]  wr_ppn,
    input  logic [SZ_W-1:0]   wr_size,
    input  logic              wr_share,
    input  logic              wr_cache,
    input  logic              wr_dirty,
    input  logic              wr_wt,
    input  logic [PROT_W-1:0] wr_prot,
    input  logic              inv_all,
    output logic              rs_valid,
    output logic              rs_hit,
    output logic              rs_multi,
    output logic [PA_W-1:0]   rs_paddr,
    output logic [PROT_W-1:0] rs_prot,
    output logic              rs_cache,
    output logic              rs_dirty,
    output logic              rs_wt,
    output logic              rs_share
);

    typedef struct packed {
        logic            valid;
        logic            hit;
        logic            multi;
        logic [PA_W-1:0] paddr;
        pg_attr_t        attr;
    } lk_res_t;

    pg_rec_t wr_rec;
    logic    asid_chk;

    logic [N_ENTRIES-1:0]           match;
    logic [N_ENTRIES-1:0][PA_W-1:0] slot_pa;
    pg_attr_t [N_ENTRIES-1:0]       slot_attr;

    logic            m_hit, m_multi;
    logic [PA_W-1:0] m_paddr;
    pg_attr_t        m_attr;

    lk_res_t res_d, res_q;

    always_comb begin
        wr_rec.valid      = wr_valid;
        wr_rec.asid       = wr_asid;
        wr_rec.vpn        = wr_vpn;
        wr_rec.ppn        = wr_ppn;
        wr_rec.size       = wr_size;
        wr_rec.attr.prot  = wr_prot;
        wr_rec.attr.cache = wr_cache;
        wr_rec.attr.dirty = wr_dirty;
        wr_rec.attr.wt    = wr_wt;
        wr_rec.attr.share = wr_share;
        asid_chk          = !lk_single_vm || lk_user;
    end

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_slot
        vpsz_tlb_slot #(
            .IDX_W  (IDX_W),
            .MY_IDX (g)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en),
            .wr_index (wr_index),
            .wr_rec   (wr_rec),
            .inv_all  (inv_all),
            .lk_vaddr (lk_vaddr),
            .lk_asid  (lk_asid),
            .asid_chk (asid_chk),
            .match    (match[g]),
            .xl_paddr (slot_pa[g]),
            .xl_attr  (slot_attr[g])
        );
    end

    vpsz_tlb_merge #(
        .N_ENTRIES (N_ENTRIES)
    ) u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .match     (match),
        .slot_pa   (slot_pa),
        .slot_attr (slot_attr),
        .hit       (m_hit),
        .multi     (m_multi),
        .paddr     (m_paddr),
        .attr      (m_attr)
    );

    always_comb begin
        res_d       = res_q;
        res_d.valid = lk_valid;
        if (lk_valid) begin
            res_d.hit   = m_hit;
            res_d.multi = m_multi;
            res_d.paddr = m_paddr;
            res_d.attr  = m_attr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign rs_valid = res_q.valid;
    assign rs_hit   = res_q.hit;
    assign rs_multi = res_q.multi;
    assign rs_paddr = res_q.paddr;
    assign rs_prot  = res_q.attr.prot;
    assign rs_cache = res_q.attr.cache;
    assign rs_dirty = res_q.attr.dirty;
    assign rs_wt    = res_q.attr.wt;
    assign rs_share = res_q.attr.share;

    a_r1_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rs_valid);

    a_r1_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!rs_valid && $stable(rs_paddr) && $stable(rs_hit)));

    a_r5_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && m_hit) |=> (rs_paddr[PG_MIN-1:0] == $past(lk_vaddr[PG_MIN-1:0])));

    a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        rs_multi |-> !rs_hit);

endmodule

// File: tb/vpsz_tlb_bench.sv
module vpsz_tlb_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 0;
    logic [31:0] lk_vaddr = '0;
    logic [7:0]  lk_asid = '0;
    logic        lk_single_vm = 0, lk_user = 0;
    logic        wr_en = 0;
    logic [5:0]  wr_index = '0;
    logic        wr_valid = 0;
    logic [21:0] wr_vpn = '0;
    logic [7:0]  wr_asid = '0;
    logic [18:0] wr_ppn = '0;
    logic [3:0]  wr_size = '0;
    logic        wr_share = 0, wr_cache = 0, wr_dirty = 0, wr_wt = 0;
    logic [5:0]  wr_prot = '0;
    logic        inv_all = 0;
    logic        rs_valid, rs_hit, rs_multi;
    logic [28:0] rs_paddr;
    logic [5:0]  rs_prot;
    logic        rs_cache, rs_dirty, rs_wt, rs_share;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    vpsz_tlb u_vpsz_tlb (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_asid(lk_asid), .lk_single_vm(lk_single_vm), .lk_user(lk_user),
        .wr_en(wr_en), .wr_index(wr_index), .wr_valid(wr_valid), .wr_vpn(wr_vpn),
        .wr_asid(wr_asid), .wr_ppn(wr_ppn), .wr_size(wr_size), .wr_share(wr_share),
        .wr_cache(wr_cache), .wr_dirty(wr_dirty), .wr_wt(wr_wt), .wr_prot(wr_prot),
        .inv_all(inv_all), .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_multi(rs_multi),
        .rs_paddr(rs_paddr), .rs_prot(rs_prot), .rs_cache(rs_cache),
        .rs_dirty(rs_dirty), .rs_wt(rs_wt), .rs_share(rs_share)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int shift_of(input int code);
        int t[8] = '{10, 12, 13, 16, 18, 20, 22, 26};
        return t[code];
    endfunction

    function automatic logic [28:0] exp_pa(input logic [31:0] va, input logic [18:0] ppn, input int code);
        logic [28:0] off;
        off = 29'((64'd1 << shift_of(code)) - 1);
        return ({ppn, 10'b0} & ~off) | (va[28:0] & off);
    endfunction

    task automatic wr(input int idx, input bit v, input logic [21:0] vpn, input logic [7:0] asid,
                      input logic [18:0] ppn, input int size, input bit sh, input logic [5:0] prot,
                      input bit c, input bit d, input bit w);
        @(negedge clk);
        wr_en = 1; wr_index = 6'(idx); wr_valid = v; wr_vpn = vpn; wr_asid = asid;
        wr_ppn = ppn; wr_size = 4'(size); wr_share = sh; wr_prot = prot;
        wr_cache = c; wr_dirty = d; wr_wt = w;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic look(input logic [31:0] va, input logic [7:0] asid, input bit sv, input bit us);
        @(negedge clk);
        lk_valid = 1; lk_vaddr = va; lk_asid = asid; lk_single_vm = sv; lk_user = us;
        @(negedge clk);
        lk_valid = 0;
    endtask

    task automatic clear_all();
        @(negedge clk);
        inv_all = 1;
        @(negedge clk);
        inv_all = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] va;
        logic [28:0] held;
        repeat (3) @(negedge clk);
        // R13: reset state
        chk(!rs_valid && !rs_hit && !rs_multi && rs_paddr == 0, "R13 reset outputs", rs_paddr, 0);
        rst_n = 1;
        look(32'h1234_5678, 8'h00, 1, 0);
        chk(rs_valid && !rs_hit && !rs_multi, "R13 empty after reset", rs_hit, 0);

        // R2, R12: every slot by index, attributes returned
        for (int i = 0; i < 64; i++)
            wr(i, 1, 22'(32'h100 + i * 37), 8'h00, 19'(i * 3 + 7), 0, 1,
               6'(i), i[0], i[1], i[2]);
        for (int i = 0; i < 64; i++) begin
            va = {22'(32'h100 + i * 37), 10'(i * 11)};
            look(va, 8'hFF, 0, 1);
            chk(rs_hit && rs_paddr == exp_pa(va, 19'(i * 3 + 7), 0), "R2 slot hit",
                rs_paddr, exp_pa(va, 19'(i * 3 + 7), 0));
            chk(rs_prot == 6'(i) && rs_cache == i[0] && rs_dirty == i[1] && rs_wt == i[2] && rs_share,
                "R12 attributes", {rs_prot, rs_cache, rs_dirty, rs_wt}, {6'(i), i[0], i[1], i[2]});
        end
        // R1: results hold without strobe
        held = rs_paddr;
        repeat (3) @(negedge clk);
        chk(!rs_valid && rs_hit && rs_paddr == held, "R1 hold", rs_paddr, held);

        // R2: invalidate one entry by writing valid 0
        wr(7, 0, 22'(32'h100 + 7 * 37), 8'h00, 19'(28), 0, 1, 0, 0, 0, 0);
        look({22'(32'h100 + 7 * 37), 10'h0}, 8'h00, 0, 1);
        chk(!rs_hit && !rs_multi && rs_paddr == 0 && rs_prot == 0, "R10 miss after invalidate", rs_paddr, 0);

        // R11: clear-all with write in the same cycle
        @(negedge clk);
        inv_all = 1; wr_en = 1; wr_index = 6'd50; wr_valid = 1; wr_vpn = 22'h3A_BCDE;
        wr_size = 0; wr_share = 1;
        @(negedge clk);
        inv_all = 0; wr_en = 0;
        look({22'h3A_BCDE, 10'h0}, 8'h00, 0, 1);
        chk(!rs_hit, "R11 write dropped under clear-all", rs_hit, 0);
        look({22'(32'h100 + 3 * 37), 10'h0}, 8'h00, 0, 1);
        chk(!rs_hit, "R11 entries cleared", rs_hit, 0);

        // R3, R5: size sweep, boundary bits
        for (int c = 0; c < 8; c++) begin
            int s;
            logic [21:0] vstore;
            logic [18:0] ppn;
            s = shift_of(c);
            va = 32'hB7E1_5163 ^ 32'(c * 32'h0404_0404);
            vstore = va[31:10] ^ 22'((64'd1 << (s - 10)) - 1);
            ppn = 19'h5_A5A5 ^ 19'(c * 19'h1111);
            wr(c + 20, 1, vstore, 8'h11, ppn, c, 0, 6'h2A, 1, 0, 1);
            look(va, 8'h11, 0, 0);
            chk(rs_hit && rs_paddr == exp_pa(va, ppn, c), "R5 splice", rs_paddr, exp_pa(va, ppn, c));
            look(va ^ (32'd1 << (s - 1)), 8'h11, 0, 0);
            chk(rs_hit && rs_paddr == exp_pa(va ^ (32'd1 << (s - 1)), ppn, c), "R3 inside page",
                rs_paddr, exp_pa(va ^ (32'd1 << (s - 1)), ppn, c));
            look(va ^ (32'd1 << s), 8'h11, 0, 0);
            chk(!rs_hit, "R3 lowest compared bit", rs_hit, 0);
            look(va ^ 32'h8000_0000, 8'h11, 0, 0);
            chk(!rs_hit, "R3 top bit", rs_hit, 0);
            wr(c + 20, 0, vstore, 8'h11, ppn, c, 0, 0, 0, 0, 0);
        end

        // R4: reserved size codes
        for (int c = 8; c < 16; c++) begin
            wr(2, 1, 22'h2_4680, 8'h00, 19'h1, c, 1, 0, 0, 0, 0);
            look({22'h2_4680, 10'h0}, 8'h00, 1, 0);
            chk(!rs_hit && !rs_multi, "R4 reserved code", c, 0);
        end
        wr(2, 0, 22'h0, 8'h00, 19'h0, 0, 0, 0, 0, 0, 0);

        // R6, R7, R8: identifier matrix
        for (int m = 0; m < 8; m++) begin
            bit sh, sv, us, exp_hit;
            sh = m[0]; sv = m[1]; us = m[2];
            wr(0, 1, 22'h1_5555, 8'h3C, 19'h7_0000, 1, sh, 0, 0, 0, 0);
            look({22'h1_5555, 10'h155}, 8'hC3, sv, us);
            exp_hit = sh || (sv && !us);
            chk(rs_hit == exp_hit, sh ? "R6 shared page" : (sv && !us) ? "R8 privileged single" : "R7 asid mismatch",
                rs_hit, exp_hit);
            look({22'h1_5555, 10'h155}, 8'h3C, sv, us);
            chk(rs_hit, "R7 asid equal", rs_hit, 1);
        end
        wr(0, 0, 22'h0, 8'h00, 19'h0, 0, 0, 0, 0, 0, 0);

        // R9: overlapping pages
        wr(10, 1, 22'h3F_FC00, 8'h00, 19'h0_1234, 1, 1, 6'h3F, 1, 1, 1);
        wr(20, 1, 22'h3F_0000, 8'h00, 19'h7_C000, 7, 1, 6'h01, 1, 1, 1);
        look(32'hFFF0_0ABC, 8'h00, 0, 0);
        chk(rs_multi && !rs_hit && rs_paddr == 0 && rs_prot == 0 && !rs_cache, "R9 multiple", rs_paddr, 0);
        wr(20, 0, 22'h0, 8'h00, 19'h0, 7, 1, 0, 0, 0, 0);
        look(32'hFFF0_0ABC, 8'h00, 0, 0);
        chk(rs_hit && !rs_multi && rs_paddr == exp_pa(32'hFFF0_0ABC, 19'h0_1234, 1), "R9 back to single",
            rs_paddr, exp_pa(32'hFFF0_0ABC, 19'h0_1234, 1));

        // R2: write and lookup at the same edge
        @(negedge clk);
        wr_en = 1; wr_index = 6'd33; wr_valid = 1; wr_vpn = 22'h0A_0A0A; wr_size = 0;
        wr_share = 1; wr_ppn = 19'h0_0777;
        lk_valid = 1; lk_vaddr = {22'h0A_0A0A, 10'h3FF}; lk_asid = 0;
        @(negedge clk);
        wr_en = 0; lk_valid = 0;
        chk(!rs_hit, "R2 same-edge lookup sees old", rs_hit, 0);
        look({22'h0A_0A0A, 10'h3FF}, 8'h00, 0, 0);
        chk(rs_hit && rs_paddr == {19'h0_0777, 10'h3FF}, "R2 next lookup sees new", rs_paddr, {19'h0_0777, 10'h3FF});

        clear_all();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule